// File: doc/BRIEF.md
# Dual-Divider Phase-Frequency Detector Core

This block is the digital heart of a frequency-synthesis loop. Two programmable 16-bit ratio counters run side by side. One divides the crystal reference and the other divides the prescaled oscillator. Both input clocks reach the block as single-cycle tick strobes in the core clock domain. Each counter emits a one-cycle terminal pulse once every N ticks. A phase-frequency detector turns the two terminal pulses into pump-up and pump-down requests for an external charge pump. Pump-up means the reference is ahead and pump-down means the oscillator is ahead.

A small write port sets the two ratios and a 2-bit pump-strength code. The code selects 25, 100, 500 or 2000 µA (codes 0, 1, 2 and 3) in the analog pump. A new ratio is only staged when it is written. The counter adopts it at the end of the period in progress, so a divided edge is never cut short. A ratio write also flushes the detector and the lock tracker, so the next comparison starts clean. A lock flag rises after a run of closely matched comparisons.

Top module: `pfd_synth_core`

## Requirements
- R1: With ratio N, each divider produces one terminal pulse per N input ticks. With ticks on every core cycle and equal ratios of 5, pump_up rises exactly 20 times in any 100 consecutive cycles.
- R2: A written ratio of 0 or 1 behaves as 2.
- R3: A written ratio takes effect only after the current division period completes. The period running at the time of the write keeps its old length.
- R4: A reference terminal pulse sets pump_up and an oscillator terminal pulse sets pump_dn, one cycle later. Once both are high, both are low in the following cycle, unless a new terminal pulse sets one of them again.
- R5: When the divided edges coincide, pump_up and pump_dn are high together for exactly one cycle, and neither is ever high alone.
- R6: A comparison ends in the cycle where both requests are high. It is good if at most one reference tick fell while exactly one request was high. locked is 1 after 16 consecutive good comparisons, and any bad comparison clears the count.
- R7: A write with cfg_sel = 2 loads pump_code from cfg_data[1:0]. The other data bits are ignored, and pump_code holds its value without such a write.
- R8: A ratio write (cfg_sel = 0 for the reference, 1 for the oscillator) clears pump_up, pump_dn and locked in the next cycle. A pump-code write or a cfg_sel = 3 write clears none of them, and a cfg_sel = 3 write changes nothing.
- R9: After reset, pump_up, pump_dn, pump_code and locked are all 0, and both ratios are 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One strobe per crystal reference cycle |
| osc_tick | input | 1 | One strobe per prescaled oscillator cycle |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_sel | input | 2 | Target: 0 reference ratio, 1 oscillator ratio, 2 pump code, 3 none |
| cfg_data | input | 16 | Write data |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| pump_code | output | 2 | Selected pump-current magnitude code |
| locked | output | 1 | Loop considered locked |

## Verification
The first pattern drives both tick streams on every cycle with equal ratios. It shows that coinciding divided edges give only paired one-cycle pulses and that lock is reached. The second pattern uses ratios of 5 and 6. Its steady phase drift must keep lock away, which separates a correct mismatch measure from one that never fails. Ratio writes made mid-period, together with ratio values 0 and 1, show whether the staging and the clamping are applied. A slow reference stream against a fast oscillator stream, with equal divided frequencies, tests the mismatch measure counted in reference ticks rather than in core cycles.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int RATIO_W  = 16;
  localparam int MIN_DIV  = 2;
  localparam int MISS_W   = 2;

  typedef enum logic [1:0] {
    SEL_REF  = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_PUMP = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // ratios below the minimum are raised to it
  function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
    return (r < RATIO_W'(MIN_DIV)) ? RATIO_W'(MIN_DIV) : r;
  endfunction

  // a comparison is good when at most one reference tick was unmatched
  function automatic logic miss_ok(input logic [MISS_W-1:0] m);
    return m <= MISS_W'(1);
  endfunction

  // saturating increment of the mismatch tally
  function automatic logic [MISS_W-1:0] miss_inc(input logic [MISS_W-1:0] m);
    return (m >= MISS_W'(2)) ? m : m + MISS_W'(1);
  endfunction
endpackage

// File: rtl/ratio_divider.sv
module ratio_divider
  import pfd_pkg::*;
#(
  parameter int RESET_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [RATIO_W-1:0] load_val,
  output logic               term,
  output logic [RATIO_W-1:0] ratio_now
);
  localparam logic [RATIO_W-1:0] RST_R = clamp_ratio(RATIO_W'(RESET_RATIO));

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] pend;
  logic               wrap;

  assign wrap = tick && (cnt == ratio_now - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ratio_now <= RST_R;
      pend      <= RST_R;
      term      <= 1'b0;
    end else begin
      term <= wrap;
      if (load) pend <= clamp_ratio(load_val);
      if (wrap) begin
        cnt       <= '0;
        ratio_now <= pend;
      end else if (tick) begin
        cnt <= cnt + RATIO_W'(1);
      end
    end
  end
endmodule

// File: rtl/phase_detector.sv
module phase_detector (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_term,
  input  logic osc_term,
  input  logic flush,
  output logic up,
  output logic dn,
  output logic both
);
  assign both = up && dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (flush) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= (up && !both) || ref_term;
      dn <= (dn && !both) || osc_term;
    end
  end
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
  import pfd_pkg::*;
#(
  parameter int LOCK_CMP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic up,
  input  logic dn,
  input  logic flush,
  output logic locked
);
  localparam int SW = $clog2(LOCK_CMP + 1);

  logic [MISS_W-1:0] miss;
  logic [SW-1:0]     streak;
  logic              cmp_end;

  assign cmp_end = up && dn;
  assign locked  = (streak == SW'(LOCK_CMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss   <= '0;
      streak <= '0;
    end else if (flush) begin
      miss   <= '0;
      streak <= '0;
    end else if (cmp_end) begin
      miss <= '0;
      if (!miss_ok(miss))  streak <= '0;
      else if (!locked)    streak <= streak + SW'(1);
    end else if ((up ^ dn) && ref_tick) begin
      miss <= miss_inc(miss);
    end
  end
endmodule

// File: rtl/pfd_synth_core.sv
module pfd_synth_core
  import pfd_pkg::*;
#(
  parameter int RESET_RATIO = 4,
  parameter int LOCK_CMP    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               osc_tick,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [RATIO_W-1:0] cfg_data,
  output logic               pump_up,
  output logic               pump_dn,
  output logic [1:0]         pump_code,
  output logic               locked
);
  localparam int NDIV = 2;

  logic [NDIV-1:0]    tick_v;
  logic [NDIV-1:0]    term_v;
  logic [RATIO_W-1:0] ratio_v [NDIV];

  // named internal events, visible to the checker
  logic               ref_term, osc_term;
  logic [RATIO_W-1:0] ref_ratio_now, main_ratio_now;
  logic               det_flush, cmp_both;

  assign tick_v    = {osc_tick, ref_tick};
  assign det_flush = cfg_wr && (cfg_sel == SEL_REF || cfg_sel == SEL_MAIN);

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    ratio_divider #(.RESET_RATIO(RESET_RATIO)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_v[i]),
      .load     (cfg_wr && (cfg_sel == 2'(i))),
      .load_val (cfg_data),
      .term     (term_v[i]),
      .ratio_now(ratio_v[i])
    );
  end

  assign ref_term       = term_v[0];
  assign osc_term       = term_v[1];
  assign ref_ratio_now  = ratio_v[0];
  assign main_ratio_now = ratio_v[1];

  phase_detector u_pfd (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_term(ref_term),
    .osc_term(osc_term),
    .flush   (det_flush),
    .up      (pump_up),
    .dn      (pump_dn),
    .both    (cmp_both)
  );

  lock_monitor #(.LOCK_CMP(LOCK_CMP)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_tick(ref_tick),
    .up      (pump_up),
    .dn      (pump_dn),
    .flush   (det_flush),
    .locked  (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pump_code <= 2'b00;
    else if (cfg_wr && cfg_sel == SEL_PUMP) pump_code <= cfg_data[1:0];
  end
endmodule

// File: rtl/pfd_synth_checks.sv
module pfd_synth_checks
  import pfd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [1:0]         cfg_sel,
  input logic               pump_up,
  input logic               pump_dn,
  input logic [1:0]         pump_code,
  input logic               locked,
  input logic               ref_term,
  input logic               osc_term,
  input logic [RATIO_W-1:0] ref_ratio_now,
  input logic [RATIO_W-1:0] main_ratio_now
);
  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ratio_now >= RATIO_W'(MIN_DIV)) && (main_ratio_now >= RATIO_W'(MIN_DIV))); // R2

  AST_REF_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_term |=> !ref_term); // R1

  AST_OSC_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    osc_term |=> !osc_term); // R1

  AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |=> !(pump_up && pump_dn)); // R4

  AST_RATIO_WRITE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_sel == SEL_REF || cfg_sel == SEL_MAIN)) |=> (!pump_up && !pump_dn && !locked)); // R8

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_sel == SEL_PUMP) |=> $stable(pump_code)); // R7

  AST_LOCK_ON_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pump_up && pump_dn)); // R6
endmodule

bind pfd_synth_core pfd_synth_checks u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr        (cfg_wr),
  .cfg_sel       (cfg_sel),
  .pump_up       (pump_up),
  .pump_dn       (pump_dn),
  .pump_code     (pump_code),
  .locked        (locked),
  .ref_term      (ref_term),
  .osc_term      (osc_term),
  .ref_ratio_now (ref_ratio_now),
  .main_ratio_now(main_ratio_now)
);

// File: tb/sim_pfd_synth_core.sv
`timescale 1ns/1ps
module sim_pfd_synth_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, osc_tick = 1'b0, cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_data = 16'd0;
  logic        pump_up, pump_dn, locked;
  logic [1:0]  pump_code;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R4";
  int rises = 0, excl = 0, gk = 0;
  bit prev_up = 0;

  always #10 clk = ~clk;

  pfd_synth_core u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_tick(osc_tick),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_code(pump_code), .locked(locked)
  );

  // behavioural reference model
  int m_cnt[2], m_act[2], m_pend[2];
  bit m_term[2];
  bit m_up, m_dn;
  int m_miss, m_streak, m_code;

  function automatic int bclamp(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_act[i] = 4; m_pend[i] = 4; m_term[i] = 0;
      end
      m_up = 0; m_dn = 0; m_miss = 0; m_streak = 0; m_code = 0;
    end else begin
      bit pair, fl, nu, nd;
      bit t[2];
      pair = m_up && m_dn;
      fl = cfg_wr && (cfg_sel < 2);
      nu = fl ? 1'b0 : ((m_up && !pair) || m_term[0]);
      nd = fl ? 1'b0 : ((m_dn && !pair) || m_term[1]);
      if (fl) begin
        m_miss = 0; m_streak = 0;
      end else if (pair) begin
        if (m_miss <= 1) m_streak = (m_streak < 16) ? m_streak + 1 : 16;
        else m_streak = 0;
        m_miss = 0;
      end else if ((m_up != m_dn) && ref_tick) begin
        m_miss = (m_miss < 2) ? m_miss + 1 : 2;
      end
      t[0] = ref_tick; t[1] = osc_tick;
      for (int i = 0; i < 2; i++) begin
        m_term[i] = 0;
        if (t[i]) begin
          if (m_cnt[i] == m_act[i] - 1) begin
            m_cnt[i] = 0; m_act[i] = m_pend[i]; m_term[i] = 1;
          end else m_cnt[i]++;
        end
        if (cfg_wr && cfg_sel == 2'(i)) m_pend[i] = bclamp(int'(cfg_data));
      end
      if (cfg_wr && cfg_sel == 2'd2) m_code = int'(cfg_data[1:0]);
      m_up = nu; m_dn = nd;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // sample at the falling edge, then drive the next inputs
  task automatic cyc(input bit rt, input bit ot, input bit wr, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    if (rst_n) begin
      chk(tag, "pump_up", int'(pump_up), int'(m_up));
      chk(tag, "pump_dn", int'(pump_dn), int'(m_dn));
      chk("R7", "pump_code", int'(pump_code), m_code);
      chk("R6", "locked", int'(locked), (m_streak == 16) ? 1 : 0);
      if (pump_up && !prev_up) rises++;
      if (pump_up != pump_dn) excl++;
      prev_up = pump_up;
    end
    ref_tick = rt; osc_tick = ot; cfg_wr = wr; cfg_sel = s; cfg_data = d;
  endtask

  task automatic run(input int n, input int rp, input int op);
    for (int k = 0; k < n; k++) begin
      cyc((gk % rp) == 0, (gk % op) == 0, 1'b0, 2'd0, 16'd0);
      gk++;
    end
  endtask

  task automatic wr_cfg(input logic [1:0] s, input logic [15:0] d);
    cyc(1'b1, 1'b1, 1'b1, s, d);
    gk++;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9", "pump_up after reset", int'(pump_up), 0);
    chk("R9", "pump_dn after reset", int'(pump_dn), 0);
    chk("R9", "pump_code after reset", int'(pump_code), 0);
    chk("R9", "locked after reset", int'(locked), 0);

    // aligned streams, equal ratios
    tag = "R4";
    wr_cfg(2'd0, 16'd5);
    wr_cfg(2'd1, 16'd5);
    run(60, 1, 1);
    rises = 0; excl = 0;
    run(100, 1, 1);
    chk("R1", "pump_up rises in 100 cycles", rises, 20);
    chk("R5", "cycles with one request alone", excl, 0);
    chk("R6", "locked on aligned edges", int'(locked), 1);

    // pump code writes and an unused selector
    wr_cfg(2'd2, 16'hFFFE);
    run(1, 1, 1);
    chk("R7", "pump_code upper bits ignored", int'(pump_code), 2);
    chk("R8", "locked kept by code write", int'(locked), 1);
    wr_cfg(2'd3, 16'h0003);
    run(1, 1, 1);
    chk("R8", "pump_code after sel 3 write", int'(pump_code), 2);
    chk("R8", "locked after sel 3 write", int'(locked), 1);

    // ratio write flushes detector and lock
    wr_cfg(2'd1, 16'd5);
    @(negedge clk);
    chk("R8", "pump_up after ratio write", int'(pump_up), 0);
    chk("R8", "pump_dn after ratio write", int'(pump_dn), 0);
    chk("R8", "locked after ratio write", int'(locked), 0);
    run(1, 1, 1);

    // ratios 0 and 1 clamp to 2
    tag = "R2";
    wr_cfg(2'd0, 16'd0);
    wr_cfg(2'd1, 16'd1);
    run(40, 1, 1);
    rises = 0;
    run(100, 1, 1);
    chk("R2", "pump_up rises with clamped ratio", rises, 50);

    // mid-period ratio changes
    tag = "R3";
    wr_cfg(2'd1, 16'd9);
    run(7, 1, 1);
    wr_cfg(2'd0, 16'd9);
    run(200, 1, 1);

    // drifting phase: ratios 5 and 6
    tag = "R6";
    wr_cfg(2'd0, 16'd5);
    wr_cfg(2'd1, 16'd6);
    run(600, 1, 1);
    chk("R6", "locked with frequency error", int'(locked), 0);

    // slow reference ticks against fast oscillator ticks, equal divided rate
    wr_cfg(2'd0, 16'd4);
    wr_cfg(2'd1, 16'd12);
    run(800, 3, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule